// File: doc/BRIEF.md
# Framebuffer control and interrupt registers

This block is the byte-wide register file of a framebuffer controller. It decodes a 32-byte window. One control byte carries an interrupt enable. One status byte shows a pending-interrupt flag together with fixed identification bits. A bank of plain storage bytes fills the top of the window. The lower half of the window is unpopulated.

A vertical-sync pulse from the video timing logic raises the pending flag when the enable bit is set. The pending flag drives a level interrupt line. Software acknowledges the interrupt by writing any value to the status byte.

Reads are combinational from the address, and writes take effect at the clock edge. Video timing and palette storage are handled elsewhere.

Top module: `fbreg_top`

## Requirements
- R1: While reset is asserted and after reset is released, the control byte, the pending flag, the interrupt output and every storage byte are zero.
- R2: Offset 0x10 is the control byte. A write stores all 8 bits, and a read returns them.
- R3: A read of offset 0x11 returns 0x61 when nothing is pending and 0xE1 when an interrupt is pending. The pending flag is bit 7, and 0x61 is the fixed identification value.
- R4: A vsync pulse sampled while control bit 7 is 1 sets the pending flag. The interrupt output is high from the following cycle.
- R5: A vsync pulse sampled while control bit 7 is 0 leaves the pending flag and the interrupt output unchanged.
- R6: Any write to offset 0x11 clears the pending flag, whatever data is written, and the interrupt output falls in the following cycle.
- R7: When a vsync pulse that would set the flag and a status write occur in the same cycle, the flag ends up set.
- R8: Offsets 0x12 to 0x1F are 14 storage bytes. Each reads back the last value written to it and is not affected by writes to other offsets.
- R9: Offsets 0x00 to 0x0F read as zero. Writes to them change no register.
- R10: The interrupt output always equals bit 7 of the status byte.
- R11: Clearing control bit 7 does not clear a flag that is already pending.
- R12: A vsync pulse uses the control value held before the edge, so a control write in the same cycle does not affect that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the addressed byte |
| bus_addr_i | input | 5 | Byte offset inside the window |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| vsync_i | input | 1 | One-cycle frame-end pulse |
| irq_o | output | 1 | Level interrupt, high while pending |

## Verification
The bench uses the default parameters: a 5-bit window, the enable and pending flags at bit 7, and the storage span 0x12 to 0x1F. With these values every offset, including the top byte 0x1F and the unpopulated low half, can be reached in a short run. Directed sequences place a vsync pulse and a bus write in the same cycle to cover the set-wins rule and the rule that the enable is sampled before the edge. A pseudo-random run then mixes writes and pulses across all 32 offsets against the reference model.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;
    // Decoded target of a bus address
    typedef struct packed {
        logic ctrl;
        logic stat;
        logic store;
    } fbreg_sel_t;
endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
    import fbreg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CTRL_OFS = 16,
    parameter int STAT_OFS = 17,
    parameter int STORE_LO = 18,
    parameter int DEPTH    = 14
) (
    input  logic [ADDR_W-1:0] addr_i,
    output fbreg_sel_t        sel_o,
    output logic [ADDR_W-1:0] store_off_o
);
    logic [ADDR_W-1:0] off;

    always_comb begin
        // Wraps below STORE_LO to a value >= DEPTH
        off          = addr_i - ADDR_W'(STORE_LO);
        sel_o.ctrl   = (addr_i == ADDR_W'(CTRL_OFS));
        sel_o.stat   = (addr_i == ADDR_W'(STAT_OFS));
        sel_o.store  = (off < ADDR_W'(DEPTH));
        store_off_o  = off;
    end
endmodule

// File: rtl/fbreg_irq.sv
module fbreg_irq #(
    parameter int DATA_W  = 8,
    parameter int IEN_BIT = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_wr_i,
    input  logic              stat_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              vsync_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              pend_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              pend;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       set_evt;

    always_comb begin
        st_d    = st_q;
        set_evt = vsync_i && st_q.ctrl[IEN_BIT];
        if (ctrl_wr_i) st_d.ctrl = wdata_i;
        if (set_evt)        st_d.pend = 1'b1;
        else if (stat_wr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign pend_o = st_q.pend;

    // R4
    set_on_vsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vsync_i && ctrl_o[IEN_BIT]) |=> pend_o);
    // R5
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend_o && !(vsync_i && ctrl_o[IEN_BIT])) |=> !pend_o);
    // R6
    clear_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_wr_i && !(vsync_i && ctrl_o[IEN_BIT])) |=> !pend_o);
    // R11
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !stat_wr_i) |=> pend_o);
    // R2
    ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_wr_i |=> (ctrl_o == $past(wdata_i)));
endmodule

// File: rtl/fbreg_store.sv
module fbreg_store #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [DEPTH-1:0]             hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = (off_i == ADDR_W'(g));
    end

    always_comb begin
        mem_d   = mem_q;
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_i && hit[i]) mem_d[i] = wdata_i;
            if (hit[i])         rdata_o  = mem_q[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q <= '0;
        else         mem_q <= mem_d;
    end

    // R8
    store_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(mem_q));
endmodule

// File: rtl/fbreg_top.sv
module fbreg_top
    import fbreg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int CTRL_OFS = 16,
    parameter int STAT_OFS = 17,
    parameter int STORE_LO = 18,
    parameter int STORE_HI = 31,
    parameter int IEN_BIT  = 7,
    parameter int PEND_BIT = 7,
    parameter int ID_BITS  = 8'h61
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              vsync_i,
    output logic              irq_o
);
    localparam int DEPTH = STORE_HI - STORE_LO + 1;
    localparam logic [DATA_W-1:0] ID_VAL = DATA_W'(ID_BITS);

    fbreg_sel_t        sel;
    logic [ADDR_W-1:0] store_off;
    logic [DATA_W-1:0] ctrl_val, store_rd, stat_val;
    logic              pend;

    fbreg_decode #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
        .STORE_LO(STORE_LO), .DEPTH(DEPTH)
    ) u_dec (
        .addr_i(bus_addr_i), .sel_o(sel), .store_off_o(store_off)
    );

    fbreg_irq #(.DATA_W(DATA_W), .IEN_BIT(IEN_BIT)) u_irq (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .ctrl_wr_i(bus_we_i && sel.ctrl), .stat_wr_i(bus_we_i && sel.stat),
        .wdata_i(bus_wdata_i), .vsync_i(vsync_i),
        .ctrl_o(ctrl_val), .pend_o(pend)
    );

    fbreg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_i(bus_we_i && sel.store), .off_i(store_off),
        .wdata_i(bus_wdata_i), .rdata_o(store_rd)
    );

    always_comb begin
        stat_val           = ID_VAL;
        stat_val[PEND_BIT] = stat_val[PEND_BIT] | pend;
        unique case (1'b1)
            sel.ctrl:  bus_rdata_o = ctrl_val;
            sel.stat:  bus_rdata_o = stat_val;
            sel.store: bus_rdata_o = store_rd;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_o = pend;

    // R10
    irq_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel.stat |-> (bus_rdata_o[PEND_BIT] == irq_o));
    // R9
    hole_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel.ctrl || sel.stat || sel.store) |-> (bus_rdata_o == '0));
    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vsync_i && ctrl_val[IEN_BIT] && bus_we_i && sel.stat) |=> irq_o);
endmodule

// File: tb/fbreg_top_tb_top.sv
`timescale 1ns/1ps
module fbreg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       vs = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference model state
    int ref_ctrl = 0;
    int ref_pend = 0;
    int ref_mem [32];

    always #2.5 clk = ~clk;

    fbreg_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .vsync_i(vs), .irq_o(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int mread(input int a);
        if (a == 16) return ref_ctrl;
        if (a == 17) return 32'h61 | (ref_pend << 7);
        if (a >= 18 && a <= 31) return ref_mem[a];
        return 0;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 16) return "R2";
        if (a == 17) return "R3";
        if (a >= 18) return "R8";
        return "R9";
    endfunction

    // One bus cycle: check outputs for the current state, then advance model
    task automatic step(input bit w, input int a, input int d, input bit v, input string tag);
        int set;
        we = w; addr = 5'(a); wdata = 8'(d); vs = v;
        #1;
        chk(rdata, mread(a), tag);
        chk(irq, ref_pend, "R10");
        @(posedge clk);
        set = (v && ref_ctrl[7]) ? 1 : 0;
        if (w && a == 16) ref_ctrl = d & 8'hFF;
        if (w && a >= 18 && a <= 31) ref_mem[a] = d & 8'hFF;
        if (set != 0) ref_pend = 1;
        else if (w && a == 17) ref_pend = 0;
        @(negedge clk);
    endtask

    task automatic rd(input int a, input string tag);
        step(1'b0, a, 0, 1'b0, tag);
    endtask

    initial begin
        int seed;
        for (int i = 0; i < 32; i++) ref_mem[i] = 0;
        // R1: values during reset
        addr = 5'h10;
        repeat (3) @(negedge clk);
        #1;
        chk(rdata, 0, "R1");
        chk(irq, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R3, R9: full sweep after reset
        for (int a = 0; a < 32; a++) rd(a, (a == 17) ? "R3" : "R1");

        // R2: control byte
        step(1'b1, 16, 8'h5A, 1'b0, "R2");
        rd(16, "R2");
        step(1'b1, 16, 8'h80, 1'b0, "R2");

        // R4: enabled vsync sets pending, irq next cycle
        step(1'b0, 17, 0, 1'b1, "R4");
        rd(17, "R4");
        chk(irq, 1, "R4");

        // R11: clearing the enable keeps the pending flag
        step(1'b1, 16, 8'h00, 1'b0, "R11");
        rd(17, "R11");

        // R6: any data on a status write acknowledges
        step(1'b1, 17, 8'h00, 1'b0, "R6");
        rd(17, "R6");
        chk(irq, 0, "R6");
        step(1'b1, 16, 8'h80, 1'b0, "R6");
        step(1'b0, 17, 0, 1'b1, "R6");
        step(1'b1, 17, 8'hFF, 1'b0, "R6");
        rd(17, "R6");

        // R5: vsync with enable low does nothing
        step(1'b1, 16, 8'h7F, 1'b0, "R5");
        step(1'b0, 17, 0, 1'b1, "R5");
        rd(17, "R5");
        chk(irq, 0, "R5");

        // R7: set and acknowledge together, set wins
        step(1'b1, 16, 8'h80, 1'b0, "R7");
        step(1'b1, 17, 8'h80, 1'b1, "R7");
        rd(17, "R7");
        chk(irq, 1, "R7");
        step(1'b1, 17, 8'h00, 1'b0, "R7");

        // R12: enable sampled before the edge
        step(1'b1, 16, 8'h00, 1'b0, "R12");
        step(1'b1, 16, 8'h80, 1'b1, "R12");
        rd(17, "R12");
        chk(irq, 0, "R12");
        step(1'b1, 16, 8'h00, 1'b1, "R12");
        rd(17, "R12");
        chk(irq, 1, "R12");
        step(1'b1, 17, 8'h00, 1'b0, "R12");

        // R8: storage bytes, including the top byte
        for (int a = 18; a < 32; a++) step(1'b1, a, (a * 37 + 5) & 8'hFF, 1'b0, "R8");
        for (int a = 18; a < 32; a++) rd(a, "R8");

        // R9: writes to the low half are dropped
        for (int a = 0; a < 16; a++) step(1'b1, a, 8'hFF, 1'b0, "R9");
        for (int a = 0; a < 32; a++) rd(a, "R9");

        // Mixed pseudo-random traffic
        seed = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            int a;
            seed = seed * 1103515245 + 12345;
            a = (seed >>> 8) & 31;
            step(((seed >>> 20) & 1) != 0, a, (seed >>> 12) & 8'hFF,
                 ((seed >>> 24) & 3) == 0, tag_of(a));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule